// File: doc/BRIEF.md
# Nine-Bit Multidrop Slave Receiver

This block is the slave-side link logic for a polled master/slave multidrop bus whose characters are nine bits wide. A UART receiver in front of it hands over each decoded character as a single-cycle strobe. The ninth bit separates addressing traffic from payload. When that bit is set, the low byte is an address-control value: a node address plus a direction flag. The block stays deaf to payload until an address-control character names its own node. It then either takes in a message or raises a request for the local transmitter to send one.

On a receive selection the block collects payload characters until the opening address-control character is repeated. The payload character just before that repeat is the checksum. All earlier payload characters are message bytes. These leave on a valid/data stream with a last marker. Because a character can only be known to be a message byte once two further characters have arrived, the stream runs two payload characters behind the bus. One cycle after the closing character the block pulses either frame-good or frame-error, together with the final message byte.

The controller has four states. `ST_IDLE` waits for selection. `ST_HOLD0` means selected with no payload seen. `ST_HOLD1` means one payload character is held. `ST_HOLD2` means two are held. The transitions are:
- open: `ST_IDLE` to `ST_HOLD0`.
- fill: `ST_HOLD0` to `ST_HOLD1` to `ST_HOLD2` on payload.
- stream: `ST_HOLD2` to `ST_HOLD2` on payload, releasing one byte.
- close: any hold state to `ST_IDLE` on the matching repeat.
- reject: hold state to `ST_IDLE` on an own-node character that differs from the opening one.
- abort: hold state to `ST_IDLE` on another node's address-control character.
- tx-select: `ST_IDLE` to `ST_IDLE` with a transmit request.

Top module: `ninebit_slave_rx`

## Requirements
- R1: After reset all outputs (out_valid, out_last, frame_good, frame_err, tx_req) are low and the block is unselected.
- R2: A character with bit 8 clear that arrives while the block is unselected produces no byte and no status.
- R3: A character with bit 8 set is address-control. Bits 6..0 hold the node address and bit 7 the direction (0 = master sends, 1 = slave must send). An own-node character with direction 0 selects the block for receive. Address-control for any other node leaves an unselected block unaffected.
- R4: An own-node address-control character with direction 1, seen while unselected, pulses tx_req for exactly one cycle, the cycle after it arrives.
- R5: In a selected frame, every payload character except the last one before the close is delivered in arrival order on out_valid/out_data. Each is delivered one cycle after the arrival of the payload character two positions later, or of the close.
- R6: out_last is raised together with the final message byte, one cycle after the closing character. That is the same cycle as the frame status.
- R7: The payload character just before the close must equal the modulo-256 sum of the message bytes. If it does, frame_good pulses one cycle after the close. If not, frame_err pulses instead.
- R8: An own-node address-control character that differs from the opening one in the direction bit ends the frame with a frame_err pulse and delivers no further byte.
- R9: Address-control for another node during a frame aborts it silently: no status, no further bytes, and later payload is ignored.
- R10: A close with no payload character at all gives frame_err. An empty message whose checksum character is 0x00 gives frame_good.
- R11: frame_good and frame_err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_addr | input | 7 | This slave's node address |
| rx_valid | input | 1 | Strobe: a received character is on rx_char |
| rx_char | input | 9 | Received character, bit 8 = address-control marker |
| out_valid | output | 1 | A message byte is on out_data |
| out_data | output | 8 | Message byte |
| out_last | output | 1 | Marks the final byte of a message |
| frame_good | output | 1 | One-cycle pulse: frame closed with correct checksum |
| frame_err | output | 1 | One-cycle pulse: frame closed badly |
| tx_req | output | 1 | One-cycle pulse: master asks this slave to transmit |

## Verification
The closing character produces two results in the same cycle: the release of the last held message byte and the frame status. A byte or status that slips by a cycle would show here first. The bench records whether out_last coincides with a status pulse, and at which stream index it appears. This is done over random message lengths, with and without idle gaps between characters. Some frames are followed at once, with no gap, by a transmit selection. That makes the status pulse and the tx_req pulse fall on adjacent cycles, and both are judged against counts computed from the frame that was sent.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD0 = 2'd1,
        ST_HOLD1 = 2'd2,
        ST_HOLD2 = 2'd3
    } nbs_state_t;

endpackage

// File: rtl/nbs_char_decode.sv
// Classifies one received character against the node address and the
// address-control character that opened the current frame.
module nbs_char_decode #(
    parameter int DATA_W = 8
) (
    input  logic              rx_valid,
    input  logic [DATA_W:0]   rx_char,
    input  logic [DATA_W-2:0] node_addr,
    input  logic [DATA_W-1:0] open_char,
    output logic              is_addr,
    output logic              is_data,
    output logic              to_me,
    output logic              dir_tx,
    output logic              same_as_open
);
    localparam int ADDR_W = DATA_W - 1;

    always_comb begin
        is_addr      = rx_valid &&  rx_char[DATA_W];
        is_data      = rx_valid && !rx_char[DATA_W];
        to_me        = is_addr && (rx_char[ADDR_W-1:0] == node_addr);
        dir_tx       = rx_char[DATA_W-1];
        same_as_open = is_addr && (rx_char[DATA_W-1:0] == open_char);
    end
endmodule

// File: rtl/nbs_csum_acc.sv
// Running modulo-2^DATA_W sum of released message bytes, with a look-ahead
// term for a byte that is still held at close time.
module nbs_csum_acc #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] add_byte,
    input  logic              peek_en,
    input  logic [DATA_W-1:0] peek_byte,
    output logic [DATA_W-1:0] sum_final
);
    logic [DATA_W-1:0] sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sum_q <= '0;
        else if (clr)    sum_q <= '0;
        else if (add_en) sum_q <= sum_q + add_byte;
    end

    always_comb sum_final = sum_q + (peek_en ? peek_byte : '0);
endmodule

// File: rtl/nbs_byte_hold.sv
// Shift line of payload characters: the newest sits in stage 0, and the
// oldest leaves at the far end.
module nbs_byte_hold #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] newer,
    output logic [DATA_W-1:0] older
);
    logic [DATA_W-1:0] stg [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stg[0] <= '0;
        else if (shift_en) stg[0] <= din;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        stg[i] <= '0;
            else if (shift_en) stg[i] <= stg[i-1];
        end
    end

    assign newer = stg[0];
    assign older = stg[DEPTH-1];
endmodule

// File: rtl/ninebit_slave_rx.sv
module ninebit_slave_rx
    import nbs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-2:0] node_addr,
    input  logic              rx_valid,
    input  logic [DATA_W:0]   rx_char,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              frame_good,
    output logic              frame_err,
    output logic              tx_req
);
    localparam int HOLD_DEPTH = 2;

    nbs_state_t        state, nxt;
    logic [DATA_W-1:0] open_q;
    logic              open_load;

    logic is_addr, is_data, to_me, dir_tx, same_as_open;
    logic shift_en, acc_clr, acc_add, peek_en;
    logic [DATA_W-1:0] held_new, held_old, sum_final;

    logic              n_valid, n_last, n_good, n_err, n_tx;
    logic [DATA_W-1:0] n_data;

    nbs_char_decode #(.DATA_W(DATA_W)) u_dec (
        .rx_valid     (rx_valid),
        .rx_char      (rx_char),
        .node_addr    (node_addr),
        .open_char    (open_q),
        .is_addr      (is_addr),
        .is_data      (is_data),
        .to_me        (to_me),
        .dir_tx       (dir_tx),
        .same_as_open (same_as_open)
    );

    nbs_byte_hold #(.DATA_W(DATA_W), .DEPTH(HOLD_DEPTH)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (rx_char[DATA_W-1:0]),
        .newer    (held_new),
        .older    (held_old)
    );

    nbs_csum_acc #(.DATA_W(DATA_W)) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (acc_clr),
        .add_en    (acc_add),
        .add_byte  (held_old),
        .peek_en   (peek_en),
        .peek_byte (held_old),
        .sum_final (sum_final)
    );

    // Next state and next output values
    always_comb begin
        nxt       = state;
        open_load = 1'b0;
        shift_en  = 1'b0;
        acc_clr   = 1'b0;
        acc_add   = 1'b0;
        peek_en   = (state == ST_HOLD2);
        n_valid   = 1'b0;
        n_data    = held_old;
        n_last    = 1'b0;
        n_good    = 1'b0;
        n_err     = 1'b0;
        n_tx      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (to_me) begin
                    if (dir_tx) begin
                        n_tx = 1'b1;
                    end else begin
                        nxt       = ST_HOLD0;
                        open_load = 1'b1;
                        acc_clr   = 1'b1;
                    end
                end
            end
            ST_HOLD0, ST_HOLD1, ST_HOLD2: begin
                if (is_data) begin
                    shift_en = 1'b1;
                    if (state == ST_HOLD0)      nxt = ST_HOLD1;
                    else if (state == ST_HOLD1) nxt = ST_HOLD2;
                    else begin
                        n_valid = 1'b1;
                        acc_add = 1'b1;
                    end
                end else if (is_addr) begin
                    nxt = ST_IDLE;
                    if (same_as_open) begin
                        if (state == ST_HOLD0) begin
                            n_err = 1'b1;
                        end else begin
                            n_valid = (state == ST_HOLD2);
                            n_last  = (state == ST_HOLD2);
                            n_good  = (sum_final == held_new);
                            n_err   = (sum_final != held_new);
                        end
                    end else if (to_me) begin
                        n_err = 1'b1;
                    end
                end
            end
        endcase
    end

    // State register and frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            open_q <= '0;
        end else begin
            state <= nxt;
            if (open_load) open_q <= rx_char[DATA_W-1:0];
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_last   <= 1'b0;
            frame_good <= 1'b0;
            frame_err  <= 1'b0;
            tx_req     <= 1'b0;
        end else begin
            out_valid  <= n_valid;
            out_data   <= n_data;
            out_last   <= n_last;
            frame_good <= n_good;
            frame_err  <= n_err;
            tx_req     <= n_tx;
        end
    end

    assert_status_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_good && frame_err));

    assert_last_has_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_last_has_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (frame_good || frame_err));

    assert_tx_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> ($past(state) == ST_IDLE));

    assert_byte_from_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(state) == ST_HOLD2));

    assert_idle_payload_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rx_valid && !rx_char[DATA_W]) |=>
            (!out_valid && !frame_good && !frame_err));

    assert_status_returns_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_good || frame_err) |-> (state == ST_IDLE));
endmodule

// File: tb/ninebit_slave_rx_tb.sv
`timescale 1ns/1ps
module ninebit_slave_rx_tb;
    localparam logic [6:0] NODE  = 7'h2A;
    localparam logic [6:0] OTHER = 7'h15;
    localparam int K_GOOD = 0, K_BADSUM = 1, K_BADCLOSE = 2, K_ABORT = 3, K_NODATA = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid;
    logic [8:0] rx_char;
    logic       out_valid, out_last, frame_good, frame_err, tx_req;
    logic [7:0] out_data;

    always #2 clk = ~clk;

    ninebit_slave_rx u_dut (
        .clk(clk), .rst_n(rst_n), .node_addr(NODE),
        .rx_valid(rx_valid), .rx_char(rx_char),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .frame_good(frame_good), .frame_err(frame_err), .tx_req(tx_req)
    );

    int n_checks = 0, n_errs = 0;
    bit done = 1'b0;

    logic [7:0] got_q[$];
    int good_n, err_n, tx_n, last_idx, last_stat;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                got_q.push_back(out_data);
                if (out_last) begin
                    last_idx  = got_q.size() - 1;
                    last_stat = (frame_good || frame_err) ? 1 : 0;
                end
            end
            if (frame_good) good_n++;
            if (frame_err)  err_n++;
            if (tx_req)     tx_n++;
        end
    end

    task automatic clear_mon();
        got_q.delete();
        good_n = 0; err_n = 0; tx_n = 0; last_idx = -1; last_stat = 0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_sum(input logic [7:0] q[$]);
        logic [7:0] s = 8'h00;
        foreach (q[i]) s = s + q[i];
        return s;
    endfunction

    task automatic put(input logic [8:0] c, input int gap);
        rx_valid = 1'b1;
        rx_char  = c;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_char  = 9'h000;
        repeat (gap) @(negedge clk);
    endtask

    function automatic int rgap();
        return ($urandom_range(0, 3) == 0) ? 1 : 0;
    endfunction

    task automatic run_frame(input int kind, input int len, input bit follow_tx, input bit zero_sum);
        logic [7:0] msg[$];
        logic [7:0] exp_q[$];
        logic [7:0] opn, cs;
        int exp_good, exp_err, exp_last, mism;
        clear_mon();
        repeat ($urandom_range(0, 2)) put({1'b0, 8'($urandom)}, 0);   // R2 idle payload
        for (int i = 0; i < len; i++) msg.push_back(8'($urandom));
        opn = {1'b0, NODE};
        put({1'b1, opn}, rgap());
        exp_good = 0; exp_err = 0; exp_last = -1;
        if (kind == K_NODATA) begin
            put({1'b1, opn}, 0);
            exp_err = 1;                                            // R10
        end else if (kind == K_ABORT) begin
            foreach (msg[i]) put({1'b0, msg[i]}, rgap());
            put({1'b1, 1'b0, OTHER}, 0);                            // R9
            put({1'b0, 8'($urandom)}, 0);
            put({1'b0, 8'($urandom)}, 0);
            for (int i = 0; i + 2 < len; i++) exp_q.push_back(msg[i]);
        end else begin
            foreach (msg[i]) put({1'b0, msg[i]}, rgap());
            cs = zero_sum ? 8'h00 : byte_sum(msg);
            if (kind == K_BADSUM) cs = cs ^ 8'h01;
            put({1'b0, cs}, rgap());
            if (kind == K_BADCLOSE) begin
                put({1'b1, opn ^ 8'h80}, 0);                        // R8
                for (int i = 0; i + 1 < len; i++) exp_q.push_back(msg[i]);
                exp_err = 1;
            end else begin
                put({1'b1, opn}, 0);
                foreach (msg[i]) exp_q.push_back(msg[i]);
                if (kind == K_GOOD) exp_good = 1; else exp_err = 1;
                if (len > 0) exp_last = len - 1;
            end
        end
        if (follow_tx) put({1'b1, 1'b1, NODE}, 0);                 // R4 back to back
        repeat (3) @(negedge clk);

        check(got_q.size() == exp_q.size(), "R5 byte count", got_q.size(), exp_q.size());
        mism = 0;
        if (got_q.size() == exp_q.size())
            foreach (exp_q[i]) if (got_q[i] !== exp_q[i]) mism++;
        check(mism == 0, "R5 byte values", mism, 0);
        check(good_n == exp_good, "R7 frame_good pulses", good_n, exp_good);
        check(err_n == exp_err, "R7/R8 frame_err pulses", err_n, exp_err);
        check(last_idx == exp_last, "R6 last index", last_idx, exp_last);
        if (exp_last >= 0) check(last_stat == 1, "R6 last with status", last_stat, 1);
        check(tx_n == (follow_tx ? 1 : 0), "R4 tx pulses", tx_n, follow_tx ? 1 : 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h00C0FFEE);
        rst_n = 1'b0; rx_valid = 1'b0; rx_char = 9'h000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({out_valid, out_last, frame_good, frame_err, tx_req} == 5'b0, "R1 reset outputs",
              int'({out_valid, out_last, frame_good, frame_err, tx_req}), 0);

        // R3: whole frame for another node, and a transmit request for another node
        clear_mon();
        put({1'b1, 1'b0, OTHER}, 0);
        for (int i = 0; i < 4; i++) put({1'b0, 8'($urandom)}, 0);
        put({1'b1, 1'b0, OTHER}, 0);
        put({1'b1, 1'b1, OTHER}, 0);
        repeat (3) @(negedge clk);
        check(got_q.size() == 0 && good_n == 0 && err_n == 0 && tx_n == 0, "R3 other node ignored",
              got_q.size() + good_n + err_n + tx_n, 0);

        // R4: transmit selection alone
        clear_mon();
        put({1'b1, 1'b1, NODE}, 0);
        repeat (3) @(negedge clk);
        check(tx_n == 1 && got_q.size() == 0, "R4 tx select", tx_n, 1);

        // Directed corners
        run_frame(K_GOOD, 0, 1'b0, 1'b1);     // R10 empty message, checksum 0
        run_frame(K_BADSUM, 0, 1'b0, 1'b1);   // R10 empty, checksum nonzero
        run_frame(K_NODATA, 0, 1'b0, 1'b0);   // R10 no payload
        run_frame(K_GOOD, 1, 1'b1, 1'b0);
        run_frame(K_GOOD, 2, 1'b0, 1'b0);
        run_frame(K_GOOD, 6, 1'b1, 1'b0);
        run_frame(K_BADSUM, 4, 1'b0, 1'b0);
        run_frame(K_BADCLOSE, 3, 1'b0, 1'b0);
        run_frame(K_ABORT, 5, 1'b0, 1'b0);
        run_frame(K_ABORT, 1, 1'b1, 1'b0);

        // Random mix
        for (int n = 0; n < 60; n++)
            run_frame($urandom_range(0, 4), $urandom_range(0, 8),
                      $urandom_range(0, 3) == 0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule